// File: doc/BRIEF.md
# Phase Tag Collection Queue

This block merges phase-measurement tags from a set of reference channels and a set of output channels into a single queue. A processor drains the queue through a small register bus. Each channel delivers a 24-bit tag with a one-cycle valid pulse. The block captures a tag only when that channel's enable bit is set. Captured tags wait in a one-deep holding slot per channel until an arbiter moves them into the queue. Each queue entry carries the tag, a channel number and a gap marker.

Tags can be lost in two ways: a second tag arrives before the first has left its holding slot, or the queue is full when a tag is granted. Neither loss is silent. The next entry that reaches the queue carries the gap marker, so software knows the tag stream has a hole. The interrupt is a plain level: it is high while anything is waiting to be read. A read of the readout register returns the oldest entry and removes it from the queue in the same access.

Top module: `tag_collect_fifo`

## Requirements
- R1: A queue entry is 32 bits: tag in bits 23:0, channel number in bits 30:24, gap marker in bit 31.
- R2: Reference channel i is numbered i, and output channel j is numbered 32+j, whatever the reference channel count.
- R3: The reference enable register (bus address 1, bit i per reference channel) and the output enable register (address 2, bit j per output channel) read back what was written. A tag on a channel whose bit is 0 is ignored and produces no entry.
- R4: A tag pulse is captured at the clock edge where it is seen. At each later edge, at most one held tag enters the queue, and the lowest channel number goes first. A lone tag is readable two edges after its pulse.
- R5: A tag that arrives while its channel's holding slot is still occupied, and is not being freed in that same cycle, is dropped. The next entry written has bit 31 set.
- R6: When the arbiter grants a tag while the queue holds DEPTH entries (counted before any pop in that cycle), the tag is discarded and the next entry written has bit 31 set. The output fifoFull is high while the queue holds DEPTH entries.
- R7: After one entry has been written with bit 31 set, later entries have bit 31 clear until another drop occurs.
- R8: A read of address 3 returns the oldest entry on busRdData one cycle later and removes it. A read of address 3 while the queue is empty returns 0 and changes nothing.
- R9: Address 0 reads as status: bit 0 set when the queue is empty, bit 1 set when it is full, bits 13:8 hold the reference channel count, bits 19:16 hold the output channel count.
- R10: irq is high exactly while the queue holds at least one entry.
- R11: Reset (rstN low at a clock edge) empties the queue and holding slots, clears both enable registers and clears the pending gap marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rstN | input | 1 | Synchronous reset, active low |
| refTagValid | input | NUM_REF | One-cycle tag pulse per reference channel |
| refTagData | input | 24*NUM_REF | Tag of reference channel i in bits 24i+23:24i |
| outTagValid | input | NUM_OUT | One-cycle tag pulse per output channel |
| outTagData | input | 24*NUM_OUT | Tag of output channel j in bits 24j+23:24j |
| busAddr | input | 2 | Register address: 0 status, 1 reference enable, 2 output enable, 3 readout |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid the cycle after busRdEn |
| fifoFull | output | 1 | Queue holds DEPTH entries |
| irq | output | 1 | Level interrupt, high while an entry waits |

## Verification
If the queue pointers or occupancy count go wrong, the port-side effect shows at the next readout: an entry comes back out of order, repeated or missing, or irq and the status bits disagree with the number of tags sent, on the first read after the fault. If the arbiter or holding slots go wrong, the channel numbers come back out of order in a simultaneous-arrival sweep, two cycles after the pulses. If the gap marker logic goes wrong, bit 31 is wrong on the first entry written after a forced drop, or on the entry after that one. Sweeps over every single channel and every channel pair, plus forced overflow of both kinds, expose each of these within a few reads.

// File: rtl/tagfifo_pkg.sv
package tagfifo_pkg;
  localparam int TAG_W       = 24;
  localparam int ID_W        = 7;
  localparam int ENTRY_W     = 32;
  localparam int OUT_ID_BASE = 32;

  // register addresses
  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_REFEN  = 2'd1;
  localparam logic [1:0] ADDR_OUTEN  = 2'd2;
  localparam logic [1:0] ADDR_POP    = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic       push;      // write granted held tag into queue
    logic       pop;       // remove head entry
    logic       disc;      // gap marker for the pushed entry
    logic [5:0] grantIdx;  // internal channel index being granted
  } tagStrobe_t;
endpackage

// File: rtl/tagfifo_dpath.sv
module tagfifo_dpath
  import tagfifo_pkg::*;
#(
  parameter int NUM_REF = 32,
  parameter int NUM_OUT = 8,
  parameter int DEPTH   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [(NUM_REF+NUM_OUT)*TAG_W-1:0] chData,
  input  logic [NUM_REF+NUM_OUT-1:0] holdLoad,
  input  tagStrobe_t               strobe,
  output logic                     fifoEmpty,
  output logic                     fifoFull,
  output logic [ENTRY_W-1:0]       fifoHead
);
  localparam int NCH  = NUM_REF + NUM_OUT;
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [TAG_W-1:0]   holdData [NCH];
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PW-1:0]      wrPtr, rdPtr;
  logic [CNTW-1:0]    count;
  logic [ID_W-1:0]    pushId;
  logic [TAG_W-1:0]   pushTag;
  logic [CW-1:0]      selIdx;

  // per-channel holding slots
  for (genvar ch = 0; ch < NCH; ch++) begin : gHold
    always_ff @(posedge clk) begin
      if (holdLoad[ch]) holdData[ch] <= chData[ch*TAG_W +: TAG_W];
    end
  end

  assign selIdx  = strobe.grantIdx[CW-1:0];
  assign pushTag = holdData[selIdx];

  always_comb begin
    if (int'(selIdx) < NUM_REF) pushId = ID_W'(selIdx);
    else                        pushId = ID_W'(OUT_ID_BASE + int'(selIdx) - NUM_REF);
  end

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= {strobe.disc, pushId, pushTag};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push)
        wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)
        rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (strobe.push && !strobe.pop)      count <= count + 1'b1;
      else if (strobe.pop && !strobe.push) count <= count - 1'b1;
    end
  end

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CNTW'(DEPTH));
  assign fifoHead  = mem[rdPtr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNTW'(DEPTH)); // R6
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push && !strobe.pop |=> count == $past(count) + 1'b1); // R4
  AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop && !strobe.push |=> count == $past(count) - 1'b1); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull && !strobe.pop |=> fifoFull); // R6
endmodule

// File: rtl/tagfifo_ctrl.sv
module tagfifo_ctrl
  import tagfifo_pkg::*;
#(
  parameter int NUM_REF = 32,
  parameter int NUM_OUT = 8,
  parameter int DEPTH   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REF+NUM_OUT-1:0] chValid,
  input  logic [1:0]                 busAddr,
  input  logic                       busWrEn,
  input  logic                       busRdEn,
  input  logic [31:0]                busWrData,
  output logic [31:0]                busRdData,
  input  logic                       fifoEmpty,
  input  logic                       fifoFull,
  input  logic [ENTRY_W-1:0]         fifoHead,
  output logic [NUM_REF+NUM_OUT-1:0] holdLoad,
  output tagStrobe_t                 strobe
);
  localparam int NCH = NUM_REF + NUM_OUT;
  localparam int CW  = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NUM_REF-1:0] refEn;
  logic [NUM_OUT-1:0] outEn;
  logic [NCH-1:0]     pending, arriving, grantVec;
  logic [CW-1:0]      grantIdx;
  logic               anyGrant, overflowDrop, fullDrop, dropNow, discFlag;
  logic               pushNow, popNow;

  assign arriving = chValid & {outEn, refEn};

  // fixed priority: lowest index wins
  always_comb begin
    anyGrant = 1'b0;
    grantIdx = '0;
    grantVec = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pending[i]) begin
        anyGrant = 1'b1;
        grantIdx = CW'(i);
      end
    end
    if (anyGrant) grantVec[grantIdx] = 1'b1;
  end

  assign holdLoad     = arriving & (~pending | grantVec);
  assign overflowDrop = |(arriving & pending & ~grantVec);
  assign pushNow      = anyGrant && !fifoFull;
  assign fullDrop     = anyGrant && fifoFull;
  assign dropNow      = overflowDrop || fullDrop;
  assign popNow       = busRdEn && (busAddr == ADDR_POP) && !fifoEmpty;

  assign strobe.push     = pushNow;
  assign strobe.pop      = popNow;
  assign strobe.disc     = discFlag;
  assign strobe.grantIdx = 6'(grantIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= '0;
      discFlag <= 1'b0;
    end else begin
      pending  <= (pending & ~grantVec) | holdLoad;
      discFlag <= dropNow || (discFlag && !pushNow);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refEn     <= '0;
      outEn     <= '0;
      busRdData <= '0;
    end else begin
      if (busWrEn) begin
        if (busAddr == ADDR_REFEN) refEn <= busWrData[NUM_REF-1:0];
        if (busAddr == ADDR_OUTEN) outEn <= busWrData[NUM_OUT-1:0];
      end
      if (busRdEn) begin
        case (busAddr)
          ADDR_STATUS: busRdData <= {12'd0, 4'(NUM_OUT), 2'd0, 6'(NUM_REF), 6'd0, fifoFull, fifoEmpty};
          ADDR_REFEN:  busRdData <= 32'(refEn);
          ADDR_OUTEN:  busRdData <= 32'(outEn);
          default:     busRdData <= fifoEmpty ? 32'd0 : 32'(fifoHead);
        endcase
      end
    end
  end

  AST_DROP_SETS_DISC: assert property (@(posedge clk) disable iff (!rstN)
    dropNow |=> discFlag); // R5
  AST_DISC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    pushNow && !dropNow |=> !discFlag); // R7
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busRdEn && busAddr == ADDR_POP && fifoEmpty |=> busRdData == 32'd0); // R8
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !strobe.push); // R6
endmodule

// File: rtl/tag_collect_fifo.sv
module tag_collect_fifo
  import tagfifo_pkg::*;
#(
  parameter int NUM_REF = 32,
  parameter int NUM_OUT = 8,
  parameter int DEPTH   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_REF-1:0]         refTagValid,
  input  logic [NUM_REF*TAG_W-1:0]   refTagData,
  input  logic [NUM_OUT-1:0]         outTagValid,
  input  logic [NUM_OUT*TAG_W-1:0]   outTagData,
  input  logic [1:0]                 busAddr,
  input  logic                       busWrEn,
  input  logic                       busRdEn,
  input  logic [31:0]                busWrData,
  output logic [31:0]                busRdData,
  output logic                       fifoFull,
  output logic                       irq
);
  localparam int NCH = NUM_REF + NUM_OUT;

  logic [NCH-1:0]       holdLoad;
  logic                 fifoEmpty;
  logic [ENTRY_W-1:0]   fifoHead;
  tagStrobe_t           strobe;

  tagfifo_ctrl #(.NUM_REF(NUM_REF), .NUM_OUT(NUM_OUT), .DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN),
    .chValid({outTagValid, refTagValid}),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .fifoHead(fifoHead),
    .holdLoad(holdLoad), .strobe(strobe)
  );

  tagfifo_dpath #(.NUM_REF(NUM_REF), .NUM_OUT(NUM_OUT), .DEPTH(DEPTH)) uDpath (
    .clk(clk), .rstN(rstN),
    .chData({outTagData, refTagData}),
    .holdLoad(holdLoad), .strobe(strobe),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .fifoHead(fifoHead)
  );

  assign irq = !fifoEmpty;
endmodule

// File: tb/tag_collect_fifo_test.sv
module tag_collect_fifo_test;
  localparam int NR = 4;
  localparam int NO = 2;
  localparam int D  = 4;
  localparam int NC = NR + NO;

  logic           clk = 1'b0;
  logic           rstN;
  logic [NR-1:0]  refTagValid;
  logic [NR*24-1:0] refTagData;
  logic [NO-1:0]  outTagValid;
  logic [NO*24-1:0] outTagData;
  logic [1:0]     busAddr;
  logic           busWrEn, busRdEn;
  logic [31:0]    busWrData, busRdData;
  logic           fifoFull, irq;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 0;

  tag_collect_fifo #(.NUM_REF(NR), .NUM_OUT(NO), .DEPTH(D)) uut (
    .clk(clk), .rstN(rstN),
    .refTagValid(refTagValid), .refTagData(refTagData),
    .outTagValid(outTagValid), .outTagData(outTagData),
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData),
    .fifoFull(fifoFull), .irq(irq)
  );

  always #5 clk = ~clk;

  function automatic logic [23:0] tagOf(int ch, int salt);
    return 24'(32'h5A0000 + ch * 32'h0103 + salt * 32'h1100);
  endfunction

  function automatic logic [6:0] idOf(int ch);
    return (ch < NR) ? 7'(ch) : 7'(32 + ch - NR);
  endfunction

  function automatic logic [31:0] entryOf(int ch, int salt, bit disc);
    return {disc, idOf(ch), tagOf(ch, salt)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdData;
  endtask

  task automatic setTags(int mask, int salt);
    for (int c = 0; c < NC; c++) begin
      if (c < NR) begin
        refTagValid[c] = mask[c];
        refTagData[c*24 +: 24] = tagOf(c, salt);
      end else begin
        outTagValid[c-NR] = mask[c];
        outTagData[(c-NR)*24 +: 24] = tagOf(c, salt);
      end
    end
  endtask

  task automatic pulse(int mask, int salt);
    @(negedge clk);
    setTags(mask, salt);
    @(negedge clk);
    setTags(0, salt);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rstN = 1'b0; busAddr = 2'd0; busWrEn = 1'b0; busRdEn = 1'b0; busWrData = '0;
    refTagValid = '0; refTagData = '0; outTagValid = '0; outTagData = '0;
    idle(4);
    rstN = 1'b1;
    idle(1);

    // R11 reset state
    check("R11 irq after reset", 32'(irq), 32'd0);
    check("R11 full after reset", 32'(fifoFull), 32'd0);
    busRead(2'd0, rd);
    check("R9 status after reset", rd, 32'h1 | (32'(NR) << 8) | (32'(NO) << 16));
    busRead(2'd1, rd);
    check("R11 ref enable cleared", rd, 32'd0);
    busRead(2'd2, rd);
    check("R11 out enable cleared", rd, 32'd0);

    // R3 disabled channels ignored
    pulse((1 << NC) - 1, 0);
    idle(4);
    check("R3 disabled tags ignored irq", 32'(irq), 32'd0);
    busRead(2'd3, rd);
    check("R3 disabled tags no entry", rd, 32'd0);

    busWrite(2'd1, 32'hF);
    busWrite(2'd2, 32'h3);
    busRead(2'd1, rd);
    check("R3 ref enable readback", rd, 32'hF);
    busRead(2'd2, rd);
    check("R3 out enable readback", rd, 32'h3);

    // R1 R2 R10: every channel alone
    for (int c = 0; c < NC; c++) begin
      pulse(1 << c, c + 1);
      idle(1);
      check($sformatf("R10 irq with entry ch%0d", c), 32'(irq), 32'd1);
      busRead(2'd3, rd);
      check($sformatf("R1 R2 entry ch%0d", c), rd, entryOf(c, c + 1, 1'b0));
      idle(1);
      check($sformatf("R10 irq drained ch%0d", c), 32'(irq), 32'd0);
    end

    // R4: every pair at once, lower number first
    for (int a = 0; a < NC; a++) begin
      for (int b = a + 1; b < NC; b++) begin
        pulse((1 << a) | (1 << b), 7);
        idle(3);
        busRead(2'd3, rd);
        check($sformatf("R4 pair %0d/%0d first", a, b), rd, entryOf(a, 7, 1'b0));
        busRead(2'd3, rd);
        check($sformatf("R4 pair %0d/%0d second", a, b), rd, entryOf(b, 7, 1'b0));
      end
    end

    // R6: all channels at once, queue of depth 4 overflows
    pulse((1 << NC) - 1, 3);
    idle(10);
    check("R6 full flag", 32'(fifoFull), 32'd1);
    busRead(2'd0, rd);
    check("R9 status full", rd, 32'h2 | (32'(NR) << 8) | (32'(NO) << 16));
    for (int c = 0; c < D; c++) begin
      busRead(2'd3, rd);
      check($sformatf("R6 kept entry %0d", c), rd, entryOf(c, 3, 1'b0));
    end
    busRead(2'd3, rd);
    check("R8 empty read returns zero", rd, 32'd0);
    check("R8 empty read leaves irq low", 32'(irq), 32'd0);
    pulse(1 << 2, 9);
    idle(2);
    busRead(2'd3, rd);
    check("R6 gap marker after full drop", rd, entryOf(2, 9, 1'b1));
    pulse(1 << 3, 10);
    idle(2);
    busRead(2'd3, rd);
    check("R7 gap marker cleared", rd, entryOf(3, 10, 1'b0));

    // R5: second tag on occupied holding slot
    @(negedge clk);
    setTags(32'b11, 11);
    @(negedge clk);
    setTags(32'b10, 12);
    @(negedge clk);
    setTags(0, 0);
    idle(3);
    busRead(2'd3, rd);
    check("R5 first entry unmarked", rd, entryOf(0, 11, 1'b0));
    busRead(2'd3, rd);
    check("R5 held tag carries gap marker", rd, entryOf(1, 12 - 1, 1'b1));
    busRead(2'd3, rd);
    check("R5 dropped tag absent", rd, 32'd0);

    // R3: disabling an output channel
    busWrite(2'd2, 32'h1);
    pulse(1 << (NR + 1), 13);
    idle(3);
    check("R3 disabled output ignored", 32'(irq), 32'd0);
    pulse(1 << NR, 14);
    idle(2);
    busRead(2'd3, rd);
    check("R2 enabled output id", rd, entryOf(NR, 14, 1'b0));

    // R11: reset clears queue and enables
    pulse(1, 15);
    idle(2);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R11 reset empties queue", 32'(irq), 32'd0);
    busRead(2'd1, rd);
    check("R11 reset clears enables", rd, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule